// File: doc/BRIEF.md
# TLP Trace Filter and Formatter

This block sits beside a PCIe root complex core and watches the transaction-layer packet headers that pass through it. Each header comes with its requester ID, the index of the root port it belongs to, its direction, a flag for peer-to-peer DMA traffic and the value of a free-running timestamp. For each header the block decides whether the header is wanted. A wanted header is turned into a fixed-size trace record, which leaves as a valid/ready stream of 32-bit words. A memory writer further down stores those words.

Software programs three things while capture is off:
- a filter, which is either a set of root ports or one requester function;
- a TLP class selection and a direction selection;
- a record format.

The compact format is four dwords long, with the header fields and the low timestamp bits folded into the first dword. The wide format is eight dwords long and starts with an all-ones marker, so a reader can tell the two formats apart. When the output stalls, the block holds off the header input instead of dropping headers. The words of one record always leave back to back.

Top module: `tlp_trace_fmt`

## Requirements
- R1: After reset `outValid` is 0 and `hdrReady` is 1. The defaults are: no filter, class selection posted-only, direction selection inbound-only, compact format.
- R2: The filter matches on either of two conditions. With a nonzero `cfgPortMask` and `cfgReqEn`=0, a header matches when bit `portIdx` of the mask is set. With `cfgReqEn`=1 and a zero mask, a header matches when `reqId` equals `cfgReqId`. With both kinds set, or neither, no header is captured.
- R3: The class of a header is decoded from Fmt (header dword 0 bits 31:29) and Type (bits 28:24):
  - Type 10xxx is a message and counts as posted.
  - Type 01010 or 01011 is a completion.
  - Type 0000x with Fmt bit 30 set is a memory write and counts as posted.
  - Every other type is non-posted.
  - `cfgTypeSel` encodes 0=all, 1=posted, 2=non-posted, 3=completions.
- R4: `cfgDirSel` encodes 0=inbound (`isOutbound`=0), 1=outbound, 2=both, 3=both but not when `isP2p`=1.
- R5: In compact format, record word 0 is packed from header dword 0 (h) and the timestamp (t) as follows:
  - bits 31:30 = h[30:29] and bits 29:25 = h[28:24];
  - bit 24 = h[23] and bit 23 = h[19];
  - bit 22 = h[16] and bit 21 = h[13];
  - bits 20:11 = h[9:0] and bits 10:0 = t[10:0].
- R6: In compact format, record words 1 to 3 are header dwords 1 to 3 unchanged, and `outLast` is set on word 3.
- R7: In wide format the record is eight words long:
  - word 0 is 32'hFFFF_FFFF;
  - word 1 is `prefixDw`, or 0 when `prefixValid` is 0;
  - words 2 to 5 are header dwords 0 to 3;
  - word 6 is 0 and word 7 is the timestamp;
  - `outLast` is set on word 7.
- R8: A write on `cfgFilterWr` or `cfgModeWr` while `captureEn` is 1 is ignored.
- R9: While a record is pending, `hdrReady` is 0. While `outValid`=1 and `outReady`=0, the data stays stable. The words of a record leave in order with no gaps other than those caused by `outReady`.
- R10: The timestamp in a record is the `timeNow` value in the cycle the header was accepted.
- R11: A header that is accepted but not captured produces no output. When `captureEn` is 0, every header is accepted and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| captureEn | input | 1 | Capture enable level |
| cfgFilterWr | input | 1 | Write strobe for the filter fields |
| cfgPortMask | input | NUM_PORTS | Root-port set |
| cfgReqEn | input | 1 | Select single-requester filtering |
| cfgReqId | input | REQ_W | Requester ID to match |
| cfgModeWr | input | 1 | Write strobe for class, direction, format |
| cfgTypeSel | input | 2 | Class selection |
| cfgDirSel | input | 2 | Direction selection |
| cfgWide | input | 1 | 1 selects the 8-word format |
| hdrValid | input | 1 | Header valid |
| hdrReady | output | 1 | Header accepted when high with hdrValid |
| hdrDw0 | input | 32 | Header dword 0 |
| hdrDw1 | input | 32 | Header dword 1 |
| hdrDw2 | input | 32 | Header dword 2 |
| hdrDw3 | input | 32 | Header dword 3 |
| prefixDw | input | 32 | TLP prefix dword |
| prefixValid | input | 1 | Prefix present |
| reqId | input | REQ_W | Requester ID of the header |
| portIdx | input | $clog2(NUM_PORTS) | Root port of the header |
| isOutbound | input | 1 | 1 for outbound, 0 for inbound |
| isP2p | input | 1 | Peer-to-peer DMA traffic |
| timeNow | input | TS_W | Free-running timestamp |
| outValid | output | 1 | Record word valid |
| outReady | input | 1 | Record word taken |
| outData | output | 32 | Record word |
| outLast | output | 1 | Final word of a record |

## Verification
The filter is exercised with port sets, a single requester, both kinds selected together and neither selected. This separates a correct exclusive-filter rule from one that ORs the two kinds. Each class and direction selection is given a mix of memory writes, reads, I/O, configuration, message and completion headers, in both directions and with and without the peer-to-peer flag. That mix exposes decode errors in Fmt/Type and in the peer-to-peer exclusion. Both formats are run with the output stalled every few cycles to show that words are held and backpressure reaches the header input. Configuration writes are issued with capture on to show that they change nothing.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {SEL_ALL, SEL_POSTED, SEL_NONPOSTED, SEL_CPL} typeSel_e;
  typedef enum logic [1:0] {DIR_IN, DIR_OUT, DIR_BOTH, DIR_BOTH_NOP2P} dirSel_e;
  typedef enum logic [1:0] {CLS_POSTED, CLS_NONPOSTED, CLS_CPL} tlpClass_e;

  // control to datapath strobes
  typedef struct packed {
    logic       load;
    logic       active;
    logic       wide;
    logic [2:0] wordIdx;
  } ctrlStrobe_t;

  // fmtType = {Fmt[1:0], Type[4:0]}
  function automatic tlpClass_e classify(input logic [6:0] fmtType);
    logic [4:0] typ;
    typ = fmtType[4:0];
    if (typ[4:3] == 2'b10)              return CLS_POSTED;
    else if (typ[4:1] == 4'b0101)       return CLS_CPL;
    else if (typ[4:1] == 4'b0000)       return fmtType[6] ? CLS_POSTED : CLS_NONPOSTED;
    else                                return CLS_NONPOSTED;
  endfunction

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 3,
  parameter int REQ_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 captureEn,
  input  logic                 cfgFilterWr,
  input  logic [NUM_PORTS-1:0] cfgPortMask,
  input  logic                 cfgReqEn,
  input  logic [REQ_W-1:0]     cfgReqId,
  input  logic                 cfgModeWr,
  input  logic [1:0]           cfgTypeSel,
  input  logic [1:0]           cfgDirSel,
  input  logic                 cfgWide,
  input  logic                 hdrValid,
  output logic                 hdrReady,
  input  logic [6:0]           fmtType,
  input  logic [REQ_W-1:0]     reqId,
  input  logic [PORT_W-1:0]    portIdx,
  input  logic                 isOutbound,
  input  logic                 isP2p,
  output logic                 outValid,
  input  logic                 outReady,
  output logic                 outLast,
  output ctrlStrobe_t          strobe
);

  localparam logic [2:0] LAST_NARROW = 3'd3;
  localparam logic [2:0] LAST_WIDE   = 3'd7;

  logic [NUM_PORTS-1:0] portMaskReg;
  logic                 reqEnReg;
  logic [REQ_W-1:0]     reqIdReg;
  typeSel_e             typeSelReg;
  dirSel_e              dirSelReg;
  logic                 wideReg;

  logic       busy;
  logic       recWide;
  logic [2:0] wordIdx;
  logic [2:0] lastIdx;

  logic      filterHit, typeHit, dirHit, capture;
  tlpClass_e cls;

  // configuration, frozen while capture is on
  always_ff @(posedge clk) begin
    if (!rstN) begin
      portMaskReg <= '0;
      reqEnReg    <= 1'b0;
      reqIdReg    <= '0;
      typeSelReg  <= SEL_POSTED;
      dirSelReg   <= DIR_IN;
      wideReg     <= 1'b0;
    end else if (!captureEn) begin
      if (cfgFilterWr) begin
        portMaskReg <= cfgPortMask;
        reqEnReg    <= cfgReqEn;
        reqIdReg    <= cfgReqId;
      end
      if (cfgModeWr) begin
        typeSelReg <= typeSel_e'(cfgTypeSel);
        dirSelReg  <= dirSel_e'(cfgDirSel);
        wideReg    <= cfgWide;
      end
    end
  end

  always_comb begin
    cls = classify(fmtType);
    filterHit = 1'b0;
    if (reqEnReg && portMaskReg == '0) filterHit = (reqId == reqIdReg);
    else if (!reqEnReg && portMaskReg != '0) filterHit = portMaskReg[portIdx];
    unique case (typeSelReg)
      SEL_ALL:       typeHit = 1'b1;
      SEL_POSTED:    typeHit = (cls == CLS_POSTED);
      SEL_NONPOSTED: typeHit = (cls == CLS_NONPOSTED);
      default:       typeHit = (cls == CLS_CPL);
    endcase
    unique case (dirSelReg)
      DIR_IN:   dirHit = !isOutbound;
      DIR_OUT:  dirHit = isOutbound;
      DIR_BOTH: dirHit = 1'b1;
      default:  dirHit = !isP2p;
    endcase
  end

  assign hdrReady = !busy;
  assign capture  = hdrValid && hdrReady && captureEn && filterHit && typeHit && dirHit;
  assign lastIdx  = recWide ? LAST_WIDE : LAST_NARROW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      recWide <= 1'b0;
      wordIdx <= '0;
    end else if (capture) begin
      busy    <= 1'b1;
      recWide <= wideReg;
      wordIdx <= '0;
    end else if (busy && outReady) begin
      if (wordIdx == lastIdx) busy <= 1'b0;
      else                    wordIdx <= wordIdx + 3'd1;
    end
  end

  assign outValid       = busy;
  assign outLast        = busy && (wordIdx == lastIdx);
  assign strobe.load    = capture;
  assign strobe.active  = busy;
  assign strobe.wide    = recWide;
  assign strobe.wordIdx = wordIdx;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !outReady) |=> (busy && $stable(wordIdx) && $stable(recWide)));

  assert_filter_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> ((portMaskReg != '0) != reqEnReg));

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (captureEn && (cfgFilterWr || cfgModeWr)) |=>
      ($stable(portMaskReg) && $stable(reqEnReg) && $stable(reqIdReg) &&
       $stable(typeSelReg) && $stable(dirSelReg) && $stable(wideReg)));

  assert_off_no_capture_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!captureEn && !busy) |=> !busy);

endmodule

// File: rtl/trc_dpath.sv
module trc_dpath
  import trc_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [31:0]      hdrDw0,
  input  logic [31:0]      hdrDw1,
  input  logic [31:0]      hdrDw2,
  input  logic [31:0]      hdrDw3,
  input  logic [31:0]      prefixDw,
  input  logic             prefixValid,
  input  logic [TS_W-1:0]  timeNow,
  output logic [31:0]      outData
);

  localparam int          NUM_HDR  = 4;
  localparam int          LOW_TS   = 11;
  localparam logic [31:0] MARKER   = 32'hFFFF_FFFF;

  logic [31:0] hdrIn [NUM_HDR];
  logic [31:0] hdrReg [NUM_HDR];
  logic [31:0] preReg;
  logic [31:0] tsReg;
  logic [31:0] packedDw0;

  assign hdrIn[0] = hdrDw0;
  assign hdrIn[1] = hdrDw1;
  assign hdrIn[2] = hdrDw2;
  assign hdrIn[3] = hdrDw3;

  for (genvar i = 0; i < NUM_HDR; i++) begin : gHdr
    always_ff @(posedge clk) begin
      if (!rstN)            hdrReg[i] <= '0;
      else if (strobe.load) hdrReg[i] <= hdrIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preReg <= '0;
      tsReg  <= '0;
    end else if (strobe.load) begin
      preReg <= prefixValid ? prefixDw : 32'd0;
      tsReg  <= 32'(timeNow);
    end
  end

  assign packedDw0 = {hdrReg[0][30:29], hdrReg[0][28:24], hdrReg[0][23], hdrReg[0][19],
                      hdrReg[0][16], hdrReg[0][13], hdrReg[0][9:0], tsReg[LOW_TS-1:0]};

  always_comb begin
    outData = '0;
    if (strobe.wide) begin
      unique case (strobe.wordIdx)
        3'd0:    outData = MARKER;
        3'd1:    outData = preReg;
        3'd2:    outData = hdrReg[0];
        3'd3:    outData = hdrReg[1];
        3'd4:    outData = hdrReg[2];
        3'd5:    outData = hdrReg[3];
        3'd6:    outData = 32'd0;
        default: outData = tsReg;
      endcase
    end else begin
      unique case (strobe.wordIdx[1:0])
        2'd0:    outData = packedDw0;
        2'd1:    outData = hdrReg[1];
        2'd2:    outData = hdrReg[2];
        default: outData = hdrReg[3];
      endcase
    end
  end

  assert_marker_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && strobe.wide && strobe.wordIdx == 3'd0) |-> (outData[31:11] == 21'h1FFFFF));

endmodule

// File: rtl/tlp_trace_fmt.sv
module tlp_trace_fmt
  import trc_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int REQ_W     = 16,
  parameter int TS_W      = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         captureEn,
  input  logic                         cfgFilterWr,
  input  logic [NUM_PORTS-1:0]         cfgPortMask,
  input  logic                         cfgReqEn,
  input  logic [REQ_W-1:0]             cfgReqId,
  input  logic                         cfgModeWr,
  input  logic [1:0]                   cfgTypeSel,
  input  logic [1:0]                   cfgDirSel,
  input  logic                         cfgWide,
  input  logic                         hdrValid,
  output logic                         hdrReady,
  input  logic [31:0]                  hdrDw0,
  input  logic [31:0]                  hdrDw1,
  input  logic [31:0]                  hdrDw2,
  input  logic [31:0]                  hdrDw3,
  input  logic [31:0]                  prefixDw,
  input  logic                         prefixValid,
  input  logic [REQ_W-1:0]             reqId,
  input  logic [$clog2(NUM_PORTS)-1:0] portIdx,
  input  logic                         isOutbound,
  input  logic                         isP2p,
  input  logic [TS_W-1:0]              timeNow,
  output logic                         outValid,
  input  logic                         outReady,
  output logic [31:0]                  outData,
  output logic                         outLast
);

  localparam int PORT_W = $clog2(NUM_PORTS);

  ctrlStrobe_t strobe;

  trc_ctrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .REQ_W(REQ_W)) uCtrl (
    .clk(clk), .rstN(rstN), .captureEn(captureEn),
    .cfgFilterWr(cfgFilterWr), .cfgPortMask(cfgPortMask), .cfgReqEn(cfgReqEn),
    .cfgReqId(cfgReqId), .cfgModeWr(cfgModeWr), .cfgTypeSel(cfgTypeSel),
    .cfgDirSel(cfgDirSel), .cfgWide(cfgWide),
    .hdrValid(hdrValid), .hdrReady(hdrReady), .fmtType(hdrDw0[30:24]),
    .reqId(reqId), .portIdx(portIdx), .isOutbound(isOutbound), .isP2p(isP2p),
    .outValid(outValid), .outReady(outReady), .outLast(outLast), .strobe(strobe)
  );

  trc_dpath #(.TS_W(TS_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hdrDw0(hdrDw0), .hdrDw1(hdrDw1), .hdrDw2(hdrDw2), .hdrDw3(hdrDw3),
    .prefixDw(prefixDw), .prefixValid(prefixValid), .timeNow(timeNow),
    .outData(outData)
  );

endmodule

// File: tb/tlp_trace_fmt_test.sv
`timescale 1ns/1ps
module tlp_trace_fmt_test;

  localparam int NP = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic captureEn = 0, cfgFilterWr = 0, cfgReqEn = 0, cfgModeWr = 0, cfgWide = 0;
  logic [NP-1:0] cfgPortMask = '0;
  logic [15:0] cfgReqId = '0, reqId = '0;
  logic [1:0] cfgTypeSel = '0, cfgDirSel = '0;
  logic hdrValid = 0, hdrReady, prefixValid = 0, isOutbound = 0, isP2p = 0;
  logic [31:0] hdrDw0 = '0, hdrDw1 = '0, hdrDw2 = '0, hdrDw3 = '0, prefixDw = '0;
  logic [2:0] portIdx = '0;
  logic [31:0] timeNow = '0;
  logic outValid, outReady = 1, outLast;
  logic [31:0] outData;

  tlp_trace_fmt #(.NUM_PORTS(NP), .REQ_W(16), .TS_W(32)) uut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, recCount = 0;
  bit stallMode = 0, finished = 0;
  string curReq = "R1";
  logic [32:0] expQ[$];
  logic [31:0] seed = 32'h1234_5678;

  // model configuration
  logic [NP-1:0] mMask = '0;
  logic mReqEn = 0, mWide = 0;
  logic [15:0] mReqId = '0;
  int mType = 1, mDir = 0;
  bit prevStall = 0;
  logic [31:0] prevWord = '0;

  function automatic logic [31:0] nextRnd();
    seed = seed * 32'h41C6_4E6D + 32'h0000_3039;
    return seed;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive time and stall pattern
  always @(negedge clk) begin
    cyc++;
    timeNow <= timeNow + 32'd7;
    outReady <= stallMode ? (cyc % 3 == 2) : 1'b1;
  end

  // class: 0 posted, 1 non-posted, 2 completion
  function automatic int classOf(logic [31:0] d0);
    logic [4:0] t;
    t = d0[28:24];
    if (t[4:3] == 2'b10) return 0;
    if (t == 5'b01010 || t == 5'b01011) return 2;
    if ((t == 5'b00000 || t == 5'b00001) && d0[30]) return 0;
    return 1;
  endfunction

  task automatic modelAccept();
    bit hit, tOk, dOk;
    int c;
    logic [31:0] d0, ts;
    hit = 0;
    if (mReqEn && mMask == 0) hit = (reqId == mReqId);
    if (!mReqEn && mMask != 0) hit = mMask[portIdx];
    c = classOf(hdrDw0);
    tOk = (mType == 0) || (mType == 1 && c == 0) || (mType == 2 && c == 1) || (mType == 3 && c == 2);
    dOk = (mDir == 0) ? !isOutbound : (mDir == 1) ? isOutbound : (mDir == 2) ? 1'b1 : !isP2p;
    if (!(captureEn && hit && tOk && dOk)) return;
    d0 = hdrDw0; ts = timeNow;
    if (mWide) begin
      expQ.push_back({1'b0, 32'hFFFF_FFFF});
      expQ.push_back({1'b0, prefixValid ? prefixDw : 32'd0});
      expQ.push_back({1'b0, d0});
      expQ.push_back({1'b0, hdrDw1});
      expQ.push_back({1'b0, hdrDw2});
      expQ.push_back({1'b0, hdrDw3});
      expQ.push_back({1'b0, 32'd0});
      expQ.push_back({1'b1, ts});
    end else begin
      expQ.push_back({1'b0, d0[30:29], d0[28:24], d0[23], d0[19], d0[16], d0[13], d0[9:0], ts[10:0]});
      expQ.push_back({1'b0, hdrDw1});
      expQ.push_back({1'b0, hdrDw2});
      expQ.push_back({1'b1, hdrDw3});
    end
  endtask

  // reference model, compared every clock between edges
  always begin
    @(negedge clk);
    #2;
    if (rstN && !finished) begin
      check(outValid == (expQ.size() != 0), {curReq, " valid"}, outValid, expQ.size() != 0);
      check(hdrReady == (expQ.size() == 0), "R9 hdrReady", hdrReady, expQ.size() == 0);
      if (prevStall) check(outValid && outData == prevWord, "R9 stall hold", outData, prevWord);
      prevStall = outValid && !outReady;
      prevWord  = outData;
      if (outValid && expQ.size() != 0) begin
        check(outData == expQ[0][31:0], {curReq, " word"}, outData, expQ[0][31:0]);
        check(outLast == expQ[0][32], {curReq, " last"}, outLast, expQ[0][32]);
        if (outReady) begin
          if (expQ[0][32]) recCount++;
          void'(expQ.pop_front());
        end
      end
      if (hdrValid && hdrReady) modelAccept();
      if (!captureEn && cfgFilterWr) begin mMask = cfgPortMask; mReqEn = cfgReqEn; mReqId = cfgReqId; end
      if (!captureEn && cfgModeWr) begin mType = cfgTypeSel; mDir = cfgDirSel; mWide = cfgWide; end
    end
  end

  task automatic setFilter(logic [NP-1:0] m, logic re, logic [15:0] id);
    @(negedge clk);
    cfgPortMask = m; cfgReqEn = re; cfgReqId = id; cfgFilterWr = 1;
    @(negedge clk);
    cfgFilterWr = 0;
  endtask

  task automatic setMode(int t, int d, logic w);
    @(negedge clk);
    cfgTypeSel = 2'(t); cfgDirSel = 2'(d); cfgWide = w; cfgModeWr = 1;
    @(negedge clk);
    cfgModeWr = 0;
  endtask

  task automatic send(logic [2:0] fmt, logic [4:0] typ, int port, logic out, logic p2p,
                      logic [15:0] rid, logic pv);
    @(negedge clk);
    hdrDw0 = {fmt, typ, nextRnd()[23:0]};
    hdrDw1 = nextRnd(); hdrDw2 = nextRnd(); hdrDw3 = nextRnd(); prefixDw = nextRnd();
    prefixValid = pv; portIdx = 3'(port); isOutbound = out; isP2p = p2p; reqId = rid;
    hdrValid = 1;
    while (!hdrReady) @(negedge clk);
    @(negedge clk);
    hdrValid = 0;
  endtask

  task automatic drainAndCount(int startCnt, int expRec, string req);
    int guard = 0;
    while ((expQ.size() != 0 || outValid) && guard < 200) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    check(recCount - startCnt == expRec, {req, " record count"}, recCount - startCnt, expRec);
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #2;
    curReq = "R1";
    check(hdrReady == 1'b1, "R1 reset hdrReady", hdrReady, 1);
    check(outValid == 1'b0, "R1 reset outValid", outValid, 0);

    // R1/R2/R3/R4 defaults: posted, inbound, compact; ports 0 and 2
    setFilter(8'b0000_0101, 0, 0);
    captureEn = 1; s = recCount;
    send(3'b010, 5'b00000, 0, 0, 0, 0, 0);   // MWr in p0 : yes
    send(3'b000, 5'b00000, 0, 0, 0, 0, 0);   // MRd : class no
    send(3'b010, 5'b00000, 2, 1, 0, 0, 0);   // outbound : no
    send(3'b010, 5'b00000, 1, 0, 0, 0, 0);   // port 1 : no
    send(3'b001, 5'b10000, 2, 0, 0, 0, 0);   // Msg p2 : yes
    drainAndCount(s, 2, "R1");

    curReq = "R5"; captureEn = 0;
    setMode(0, 2, 0);
    captureEn = 1; s = recCount;
    send(3'b000, 5'b00000, 2, 1, 0, 0, 0);   // yes
    send(3'b010, 5'b01010, 0, 0, 1, 0, 0);   // yes
    send(3'b000, 5'b00100, 1, 0, 0, 0, 0);   // port 1 no
    drainAndCount(s, 2, "R6");

    curReq = "R3"; captureEn = 0;
    setMode(2, 1, 0);
    captureEn = 1; s = recCount;
    send(3'b000, 5'b00010, 0, 1, 0, 0, 0);   // IORd out : yes
    send(3'b011, 5'b00000, 0, 1, 0, 0, 0);   // MWr : no
    send(3'b010, 5'b01010, 0, 1, 0, 0, 0);   // CplD : no
    send(3'b010, 5'b00100, 2, 1, 0, 0, 0);   // CfgWr : yes
    send(3'b000, 5'b00000, 0, 0, 0, 0, 0);   // inbound : no
    drainAndCount(s, 2, "R3");

    curReq = "R4"; captureEn = 0;
    setMode(3, 3, 0);
    captureEn = 1; s = recCount;
    send(3'b000, 5'b01010, 0, 0, 0, 0, 0);   // yes
    send(3'b010, 5'b01011, 2, 1, 1, 0, 0);   // p2p : no
    send(3'b010, 5'b01010, 2, 1, 0, 0, 0);   // yes
    send(3'b010, 5'b00000, 2, 1, 0, 0, 0);   // MWr : no
    drainAndCount(s, 2, "R4");

    curReq = "R2"; captureEn = 0;
    setMode(0, 2, 0);
    setFilter(8'h00, 1, 16'h0100);
    captureEn = 1; s = recCount;
    send(3'b010, 5'b00000, 5, 0, 0, 16'h0100, 0);
    send(3'b010, 5'b00000, 5, 0, 0, 16'h0101, 0);
    send(3'b000, 5'b00000, 0, 1, 0, 16'h0100, 0);
    drainAndCount(s, 2, "R2");
    captureEn = 0;
    setFilter(8'h01, 1, 16'h0100);
    captureEn = 1; s = recCount;
    send(3'b010, 5'b00000, 0, 0, 0, 16'h0100, 0);
    drainAndCount(s, 0, "R2 both kinds");
    captureEn = 0;
    setFilter(8'h00, 0, 16'h0100);
    captureEn = 1; s = recCount;
    send(3'b010, 5'b00000, 0, 0, 0, 16'h0100, 0);
    drainAndCount(s, 0, "R2 no filter");

    curReq = "R7"; captureEn = 0;
    setFilter(8'hFF, 0, 0);
    setMode(0, 2, 1);
    captureEn = 1; s = recCount;
    send(3'b110, 5'b00000, 3, 0, 0, 0, 1);
    send(3'b010, 5'b00000, 7, 1, 0, 0, 0);
    drainAndCount(s, 2, "R7");

    curReq = "R9"; stallMode = 1; s = recCount;
    send(3'b000, 5'b00000, 1, 0, 0, 0, 1);
    send(3'b010, 5'b01010, 4, 1, 0, 0, 0);
    send(3'b001, 5'b10011, 6, 0, 0, 0, 1);
    drainAndCount(s, 3, "R9 wide");
    captureEn = 0;
    setMode(0, 2, 0);
    captureEn = 1; s = recCount;
    send(3'b000, 5'b00000, 1, 0, 0, 0, 0);
    send(3'b010, 5'b00000, 2, 1, 1, 0, 0);
    send(3'b000, 5'b00101, 3, 0, 0, 0, 0);
    drainAndCount(s, 3, "R10 narrow stalled");
    stallMode = 0;

    curReq = "R11"; captureEn = 0; s = recCount;
    send(3'b010, 5'b00000, 0, 0, 0, 0, 0);
    send(3'b000, 5'b00000, 1, 1, 0, 0, 0);
    drainAndCount(s, 0, "R11");

    curReq = "R8";
    setFilter(8'h01, 0, 0);
    captureEn = 1;
    setFilter(8'h08, 0, 0);   // ignored
    setMode(3, 1, 1);         // ignored
    s = recCount;
    send(3'b010, 5'b00000, 3, 0, 0, 0, 0);   // no
    send(3'b010, 5'b00000, 0, 0, 0, 0, 0);   // yes, compact
    drainAndCount(s, 1, "R8");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule